// File: doc/BRIEF.md
# Address-Selected Instruction Line Cache

This block is the instruction-fetch front end of a core that has a small local program RAM and a large shared memory. Each fetch presents a 16-bit word address. The address alone picks the source, and no execution-mode flag is kept. Addresses at or below 0x01FF read the local RAM. Addresses above 0x01FF are served from a small read-only instruction cache that holds whole lines of eight 32-bit words.

The core drives `fetch_req` and `fetch_addr` and holds them while `stall` is high. A fetch is accepted in a cycle where `fetch_req` is high and `stall` is low. Its word appears on `fetch_data`, with `fetch_valid` high, in the cycle after acceptance. A local fetch and a cache hit have the same timing.

On a miss the block issues one request for the line to the shared memory and waits for a grant. It then takes eight consecutive word beats and writes them into the chosen line. The word the core asked for is forwarded as soon as its beat arrives. The line becomes valid only after the last beat. With four lines, the line to replace is the least recently used one, tracked with one age counter per line.

Top module: `ifetch_line_cache`

## Requirements
- R1: After reset, `stall`, `fetch_valid` and `mem_req` are low, and every cache line is invalid.
- R2: A fetch with address at or below 0x01FF never stalls. It drives `lram_addr` with address bits [8:0], issues no shared-memory request, and returns the local RAM word (one-cycle synchronous read) on `fetch_data` in the next cycle. This holds even while a refill is in progress.
- R3: A fetch above 0x01FF whose line (tag = address bits [15:3]) is valid is accepted without stall. It returns word [2:0] of that line in the next cycle and issues no request.
- R4: A fetch above 0x01FF that misses raises `stall` in the same cycle. It then raises `mem_req` from the next cycle with `mem_addr` = {address[15:3], 3'b000}, holds both until the cycle where `mem_gnt` is high, and drops `mem_req` after it, so there is exactly one request per refill.
- R5: From the cycle after the grant, the eight cycles with `mem_rvalid` high carry line words 0 to 7 in order. The stalled fetch is accepted in the cycle where its own word is on `mem_rdata`, so with a grant delay of D cycles the fetch stalls for 3 + D + word index cycles, and it returns that beat's data.
- R6: A line is valid only after its eighth beat. A cache-region fetch made during a refill, other than one whose word is arriving in that cycle, stalls until the refill has completed and is then served from the cache.
- R7: A pulse on `invalidate` makes every line invalid. A pulse during a refill prevents that line from becoming valid, so the next fetch to it misses again.
- R8: With four lines, a miss replaces the least recently used line, and both a hit and a completed refill make their line the most recently used.
- R9: `fetch_valid` is high for exactly one cycle after each accepted fetch and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held while stalled |
| fetch_addr | input | 16 | Fetch word address |
| invalidate | input | 1 | Invalidate all cache lines |
| stall | output | 1 | The current fetch cannot be accepted |
| fetch_valid | output | 1 | fetch_data holds the word of the fetch accepted last cycle |
| fetch_data | output | 32 | Fetched instruction word |
| lram_addr | output | 9 | Local RAM read address |
| lram_rdata | input | 32 | Local RAM read data, one cycle after the address |
| mem_req | output | 1 | Line refill request |
| mem_addr | output | 16 | Base word address of the line to refill |
| mem_gnt | input | 1 | Grant of the refill request |
| mem_rvalid | input | 1 | A refill word beat is present |
| mem_rdata | input | 32 | Refill word beat data |

## Verification
The bench probes the exact region boundary at 0x01FF and 0x0200. A decoder off by one would stall a local fetch, or would return local data for the first cached word. It measures the exact stall length of a miss for different word indices and grant delays. This catches a design that forwards the wrong beat, waits for the whole line, or counts the grant cycle wrongly. It fetches an already-written word of a line still being filled, which a design that sets the valid bit early would return without stall. It also pulses invalidate in the middle of a refill and then drives a hit and miss sequence that is sensitive to the age order, so a design that keeps a killed line, or that replaces the wrong line, issues a different number of requests than expected.

// File: rtl/ifetch_pkg.sv
// Package: shared types and default geometry of the instruction line cache.
// Assumes word addressing: one fetch address selects one 32-bit word.
package ifetch_pkg;

    localparam int DEF_PC_W       = 16;
    localparam int DEF_DATA_W     = 32;
    localparam int DEF_LINE_WORDS = 8;
    localparam int DEF_NLINES     = 4;

    // Refill sequencer state.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2
    } fill_state_t;

endpackage

// File: rtl/ifetch_region_dec.sv
// Region decoder: splits the fetch space at a fixed top-of-local address.
// Assumes LOCAL_TOP + 1 is a power of two, so the local address is a plain
// bit slice of the fetch address.
module ifetch_region_dec #(
    parameter int              PC_W      = 16,
    parameter logic [PC_W-1:0] LOCAL_TOP = 16'h01FF,
    localparam int             LA_W      = $clog2(int'(LOCAL_TOP) + 1)
) (
    input  logic [PC_W-1:0] addr,
    output logic            in_cache,
    output logic [LA_W-1:0] local_addr
);

    // Address alone picks the source; no mode state.
    always_comb begin
        in_cache   = (addr > LOCAL_TOP);
        local_addr = addr[LA_W-1:0];
    end

endmodule

// File: rtl/icache_lru.sv
// Replacement chooser: one age counter per line, 0 = newest.
// Assumes ages start as a permutation and a touch keeps them a permutation.
// With a single line the victim is always line 0 and no state is kept.
module icache_lru #(
    parameter int  NLINES = 4,
    localparam int IDX_W  = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);

    generate
        if (NLINES == 1) begin : g_single
            assign victim = '0;
        end else begin : g_multi
            logic [IDX_W-1:0]  age_q [NLINES];
            logic [NLINES-1:0] newest_vec;

            // Age update: touched line becomes newest, younger lines age by one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < NLINES; i++) age_q[i] <= IDX_W'(i);
                end else if (touch) begin
                    for (int i = 0; i < NLINES; i++) begin
                        if (IDX_W'(i) == touch_idx)
                            age_q[i] <= '0;
                        else if (age_q[i] < age_q[touch_idx])
                            age_q[i] <= age_q[i] + 1'b1;
                    end
                end
            end

            // Victim pick: the line holding the oldest age.
            always_comb begin
                victim = '0;
                for (int i = 0; i < NLINES; i++) begin
                    if (age_q[i] == IDX_W'(NLINES - 1)) victim = IDX_W'(i);
                    newest_vec[i] = (age_q[i] == '0);
                end
            end

            // R8: the ages stay a permutation, so exactly one line is newest.
            p_one_newest_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(newest_vec) == 1);
        end
    endgenerate

endmodule

// File: rtl/icache_store.sv
// Line store: tags, valid bits and word data of all lines, plus hit lookup.
// Assumes at most one line is allocated or written per cycle. The data array
// has no reset; the valid bits alone guard it.
module icache_store #(
    parameter int  DATA_W     = 32,
    parameter int  LINE_WORDS = 8,
    parameter int  NLINES     = 4,
    parameter int  TAG_W      = 13,
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int IDX_W      = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [OFF_W-1:0]  lk_off,
    input  logic              invalidate,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_set,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [DATA_W-1:0] hit_data
);

    logic [DATA_W-1:0] words_q [NLINES][LINE_WORDS];
    logic [TAG_W-1:0]  tags_q  [NLINES];
    logic [NLINES-1:0] valid_q;
    logic [NLINES-1:0] hit_vec;

    // Valid and tag bookkeeping: invalidate beats allocation beats fill completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NLINES; i++) tags_q[i] <= '0;
        end else begin
            if (alloc) tags_q[alloc_idx] <= alloc_tag;
            if (invalidate)
                valid_q <= '0;
            else begin
                if (alloc)    valid_q[alloc_idx] <= 1'b0;
                if (fill_set) valid_q[wr_idx]    <= 1'b1;
            end
        end
    end

    // Refill beat write into the data array.
    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_idx][wr_off] <= wr_data;
    end

    // Per-line tag compare.
    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_cmp
            assign hit_vec[g] = valid_q[g] && (tags_q[g] == lk_tag);

            // R6: a line turns valid only right after a completed refill.
            p_valid_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(valid_q[g]) |-> $past(fill_set));
        end
    endgenerate

    // Hit encode and word select.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        hit      = |hit_vec;
        hit_data = words_q[hit_idx][lk_off];
    end

    // R8: distinct lines never hold the same valid tag.
    p_onehot_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/ifetch_line_cache.sv
// Instruction-fetch front end. Fetches at or below LOCAL_TOP read local RAM,
// and fetches above it are served by a read-only line cache refilled through
// a request/grant port. Assumes the core holds fetch_req/fetch_addr while
// stall is high, that the local RAM has a one-cycle synchronous read, and that
// the shared memory returns LINE_WORDS beats in order after the grant.
module ifetch_line_cache
    import ifetch_pkg::*;
#(
    parameter int              PC_W       = DEF_PC_W,
    parameter int              DATA_W     = DEF_DATA_W,
    parameter int              LINE_WORDS = DEF_LINE_WORDS,
    parameter int              NLINES     = DEF_NLINES,
    parameter logic [PC_W-1:0] LOCAL_TOP  = 16'h01FF,
    localparam int             OFF_W      = $clog2(LINE_WORDS),
    localparam int             TAG_W      = PC_W - OFF_W,
    localparam int             IDX_W      = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int             LA_W       = $clog2(int'(LOCAL_TOP) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [PC_W-1:0]   fetch_addr,
    input  logic              invalidate,
    output logic              stall,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic [LA_W-1:0]   lram_addr,
    input  logic [DATA_W-1:0] lram_rdata,
    output logic              mem_req,
    output logic [PC_W-1:0]   mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    fill_state_t       state_q;
    logic [IDX_W-1:0]  fill_idx_q;
    logic [TAG_W-1:0]  fill_tag_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              kill_q;
    logic              out_valid_q;
    logic              out_cache_q;
    logic [DATA_W-1:0] out_data_q;

    logic              in_cache;
    logic [TAG_W-1:0]  lk_tag;
    logic [OFF_W-1:0]  lk_off;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [DATA_W-1:0] hit_data;
    logic [IDX_W-1:0]  victim;
    logic              busy, hit_ok, fwd_now, accept, start;
    logic              beat, fill_last, fill_set, touch;
    logic [IDX_W-1:0]  touch_idx;

    ifetch_region_dec #(.PC_W(PC_W), .LOCAL_TOP(LOCAL_TOP)) i_region (
        .addr       (fetch_addr),
        .in_cache   (in_cache),
        .local_addr (lram_addr)
    );

    icache_store #(
        .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .NLINES(NLINES), .TAG_W(TAG_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (lk_tag),
        .lk_off     (lk_off),
        .invalidate (invalidate),
        .alloc      (start),
        .alloc_idx  (victim),
        .alloc_tag  (lk_tag),
        .wr_en      (beat),
        .wr_idx     (fill_idx_q),
        .wr_off     (cnt_q),
        .wr_data    (mem_rdata),
        .fill_set   (fill_set),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_data   (hit_data)
    );

    icache_lru #(.NLINES(NLINES)) i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    // Fetch decision: hit, forward, stall or refill start.
    always_comb begin
        lk_tag    = fetch_addr[PC_W-1:OFF_W];
        lk_off    = fetch_addr[OFF_W-1:0];
        busy      = (state_q != FS_IDLE);
        beat      = (state_q == FS_FILL) && mem_rvalid;
        fwd_now   = beat && fetch_req && in_cache &&
                    (cnt_q == lk_off) && (fill_tag_q == lk_tag);
        hit_ok    = in_cache && hit && !busy;
        stall     = fetch_req && in_cache && !hit_ok && !fwd_now;
        accept    = fetch_req && !stall;
        start     = (state_q == FS_IDLE) && fetch_req && in_cache && !hit;
        fill_last = beat && (cnt_q == OFF_W'(LINE_WORDS - 1));
        fill_set  = fill_last && !kill_q && !invalidate;
        touch     = (fetch_req && hit_ok) || fill_set;
        touch_idx = fill_set ? fill_idx_q : hit_idx;
        mem_req   = (state_q == FS_REQ);
        mem_addr  = {fill_tag_q, {OFF_W{1'b0}}};
    end

    // Refill sequencer: request, then count LINE_WORDS beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FS_IDLE;
            fill_idx_q <= '0;
            fill_tag_q <= '0;
            cnt_q      <= '0;
            kill_q     <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: if (start) begin
                    state_q    <= FS_REQ;
                    fill_idx_q <= victim;
                    fill_tag_q <= lk_tag;
                    kill_q     <= invalidate;
                end
                FS_REQ: begin
                    if (mem_gnt) begin
                        state_q <= FS_FILL;
                        cnt_q   <= '0;
                    end
                    if (invalidate) kill_q <= 1'b1;
                end
                FS_FILL: begin
                    if (mem_rvalid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (fill_last) state_q <= FS_IDLE;
                    end
                    if (invalidate) kill_q <= 1'b1;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Output stage: one registered result per accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_cache_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= accept;
            if (accept) out_cache_q <= in_cache;
            if (accept && in_cache) out_data_q <= fwd_now ? mem_rdata : hit_data;
        end
    end

    // Result mux: local RAM data arrives straight from its read port.
    always_comb begin
        fetch_valid = out_valid_q;
        fetch_data  = out_cache_q ? out_data_q : lram_rdata;
    end

    // R4: the request stays up until granted.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R4: a grant ends the request, so one request per refill.
    p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    // R2: local fetches never stall.
    p_local_nostall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !in_cache) |-> !stall);

    // R6: without a beat, a cache fetch during the fill must wait.
    p_fill_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_FILL) && !mem_rvalid && fetch_req && in_cache) |-> stall);

endmodule

// File: tb/test_ifetch_line_cache.sv
// Directed bench: one task per scenario, each checking its own results.
module test_ifetch_line_cache;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        invalidate = 1'b0;
    logic        stall, fetch_valid;
    logic [31:0] fetch_data;
    logic [8:0]  lram_addr;
    logic [31:0] lram_rdata = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int gnt_delay = 0;
    int req_count = 0;
    logic [15:0] last_base = '0;
    logic        done = 1'b0;

    int m_phase = 0;
    int m_wait = 0;
    int m_beat = 0;

    ifetch_line_cache i_ifetch_line_cache (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .invalidate(invalidate), .stall(stall), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .lram_addr(lram_addr), .lram_rdata(lram_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] shw(input logic [15:0] a);
        return {16'hC0DE ^ a, a};
    endfunction

    function automatic logic [31:0] lw(input logic [8:0] a);
        return {16'hA5A5, 7'd0, a};
    endfunction

    // Local RAM model: one-cycle synchronous read.
    always @(posedge clk) lram_rdata <= lw(lram_addr);

    // Shared memory model: grant after gnt_delay cycles, then 8 beats.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_gnt <= 1'b0; mem_rvalid <= 1'b0; m_phase <= 0; m_wait <= 0; m_beat <= 0;
        end else begin
            mem_gnt    <= 1'b0;
            mem_rvalid <= 1'b0;
            if (m_phase == 0) begin
                if (mem_req) begin
                    if (m_wait == gnt_delay) begin
                        mem_gnt   <= 1'b1;
                        m_wait    <= 0;
                        m_phase   <= 1;
                        last_base <= mem_addr;
                        req_count <= req_count + 1;
                    end else m_wait <= m_wait + 1;
                end
            end else if (m_phase == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= shw(last_base);
                m_beat     <= 1;
                m_phase    <= 2;
            end else begin
                if (m_beat < 8) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= shw(last_base + 16'(m_beat));
                    m_beat     <= m_beat + 1;
                end else m_phase <= 0;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One fetch, entered just after a falling edge; returns data and stall cycles.
    task automatic do_fetch(input logic [15:0] a, output logic [31:0] d,
                            output int ns, output logic v);
        ns = 0;
        fetch_req = 1'b1; fetch_addr = a;
        #1;
        while (stall && ns < 500) begin
            ns++;
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        d = fetch_data; v = fetch_valid;
        fetch_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk(stall == 1'b0, "R1 stall", 32'(stall), 0);
        chk(fetch_valid == 1'b0, "R1 fetch_valid", 32'(fetch_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        idle(1);
        chk(fetch_valid == 1'b0, "R9 idle valid", 32'(fetch_valid), 0);
    endtask

    task automatic t_local;
        logic [31:0] d; int ns; logic v; int rc;
        rc = req_count;
        do_fetch(16'h0000, d, ns, v);
        chk(d == lw(9'h000) && v, "R2 local 0000 data", d, lw(9'h000));
        do_fetch(16'h01FF, d, ns, v);
        chk(d == lw(9'h1FF), "R2 local 01FF data", d, lw(9'h1FF));
        chk(ns == 0, "R2 local no stall", 32'(ns), 0);
        chk(req_count == rc, "R2 no request", 32'(req_count), 32'(rc));
        chk(fetch_valid == 1'b1, "R9 valid after accept", 32'(fetch_valid), 1);
        idle(1);
        chk(fetch_valid == 1'b0, "R9 valid one cycle", 32'(fetch_valid), 0);
    endtask

    task automatic t_miss_forward;
        logic [31:0] d; int ns; logic v; int rc;
        gnt_delay = 0;
        rc = req_count;
        do_fetch(16'h0205, d, ns, v);
        chk(ns == 8, "R5 miss stall word 5", 32'(ns), 8);
        chk(d == shw(16'h0205), "R5 forwarded data", d, shw(16'h0205));
        chk(req_count == rc + 1, "R4 one request", 32'(req_count), 32'(rc + 1));
        chk(last_base == 16'h0200, "R4 line base", 32'(last_base), 32'h0200);
        do_fetch(16'h0202, d, ns, v);
        chk(ns == 2, "R6 wait for fill end", 32'(ns), 2);
        chk(d == shw(16'h0202), "R6 data after fill", d, shw(16'h0202));
        do_fetch(16'h0200, d, ns, v);
        chk(ns == 0 && d == shw(16'h0200), "R3 hit word 0", d, shw(16'h0200));
        do_fetch(16'h0207, d, ns, v);
        chk(ns == 0 && d == shw(16'h0207), "R3 hit word 7", d, shw(16'h0207));
        chk(req_count == rc + 1, "R3 hits no request", 32'(req_count), 32'(rc + 1));
    endtask

    task automatic t_delay_local_during_fill;
        logic [31:0] d; int ns; logic v;
        gnt_delay = 3;
        do_fetch(16'h0300, d, ns, v);
        chk(ns == 6, "R5 stall with grant delay", 32'(ns), 6);
        chk(d == shw(16'h0300), "R5 delayed data", d, shw(16'h0300));
        do_fetch(16'h0123, d, ns, v);
        chk(ns == 0 && d == lw(9'h123), "R2 local during fill", d, lw(9'h123));
        do_fetch(16'h0301, d, ns, v);
        chk(d == shw(16'h0301), "R6 word after delayed fill", d, shw(16'h0301));
        gnt_delay = 0;
        idle(2);
    endtask

    task automatic t_invalidate;
        logic [31:0] d; int ns; logic v; int rc;
        invalidate = 1'b1; idle(1); invalidate = 1'b0;
        rc = req_count;
        do_fetch(16'h0203, d, ns, v);
        chk(ns > 0 && req_count == rc + 1, "R7 miss after invalidate",
            32'(req_count), 32'(rc + 1));
        chk(d == shw(16'h0203), "R7 refetched data", d, shw(16'h0203));
        idle(12);
        rc = req_count;
        fork
            do_fetch(16'h0400, d, ns, v);
            begin
                repeat (5) @(negedge clk);
                invalidate = 1'b1;
                @(negedge clk);
                invalidate = 1'b0;
            end
        join
        idle(12);
        do_fetch(16'h0401, d, ns, v);
        chk(req_count == rc + 2, "R7 killed fill stays invalid",
            32'(req_count), 32'(rc + 2));
        chk(d == shw(16'h0401), "R7 data after refill", d, shw(16'h0401));
        idle(12);
    endtask

    task automatic lru_step(input logic [15:0] a, input logic miss, input string tag);
        logic [31:0] d; int ns; logic v; int rc;
        rc = req_count;
        do_fetch(a, d, ns, v);
        chk(req_count == rc + (miss ? 1 : 0), tag, 32'(req_count),
            32'(rc + (miss ? 1 : 0)));
        chk(d == shw(a), {tag, " data"}, d, shw(a));
        idle(12);
    endtask

    task automatic t_lru;
        invalidate = 1'b1; idle(1); invalidate = 1'b0;
        lru_step(16'h1000, 1'b1, "R8 fill A");
        lru_step(16'h2000, 1'b1, "R8 fill B");
        lru_step(16'h3000, 1'b1, "R8 fill C");
        lru_step(16'h4000, 1'b1, "R8 fill D");
        lru_step(16'h1000, 1'b0, "R8 hit A");
        lru_step(16'h5000, 1'b1, "R8 miss E");
        lru_step(16'h1000, 1'b0, "R8 A kept");
        lru_step(16'h4000, 1'b0, "R8 D kept");
        lru_step(16'h2000, 1'b1, "R8 B evicted");
        lru_step(16'h5000, 1'b0, "R8 E kept");
        lru_step(16'h3000, 1'b1, "R8 C evicted");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_local();
        t_miss_forward();
        t_delay_local_during_fill();
        t_invalidate();
        t_lru();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule